// File: doc/BRIEF.md
# Serial Flash Command Controller

This block turns single-cycle operation requests into complete serial transactions for a configuration flash attached over a one-bit SPI-style link (serial clock, active-low select, data out, data in). Five operations are available, each with its own active-high request pin: read the device identifier, read the device status byte, erase the sector holding a given address, write new protection bits into the status byte, and program a page of data. Page data is staged in an internal byte buffer through a shift-enable port before the program request is launched.

Every operation that alters the flash is preceded by its own write-enable transaction. After the altering command completes, the block keeps reading the device status until the write-in-progress flag clears. Busy stays high from the accepted request until the final chip select release. The identifier and status results are kept on two 8-bit outputs. The address width is 24 bits by default and becomes 32 bits for large devices through a parameter. The address is sent as three or four bytes.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: While `rst` is high, `busy` is 0, `spi_cs_n` is 1, `spi_sck` is 0 and `id_out` and `status_out` are 0x00. Requests present on the first two rising edges after `rst` falls are ignored.
- R2: Raising `rst` during an operation ends it. The rising edge that sees `rst` forces `spi_cs_n` high, `spi_sck` low and `busy` low.
- R3: An identifier read is one frame holding byte 0xAB and then three 0x00 bytes. The fifth byte read back is placed on `id_out`.
- R4: A status read is one frame holding byte 0x05. The byte read back after it is placed on `status_out`.
- R5: Bits go out most-significant first. `spi_sck` idles low and is high only while `spi_cs_n` is low. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled on the rising edge of `spi_sck`.
- R6: A sector erase sends a frame holding 0x06, then a frame holding 0xD8 followed by `addr`, most-significant byte first, as ADDR_W/8 bytes.
- R7: A protect operation sends a frame holding 0x06, then a frame holding 0x01 followed by the `din` value captured when the request was accepted.
- R8: While idle, every rising edge with both `req_write` and `shift_en` high stores `din` in the next buffer slot. After 256 bytes, storage wraps and overwrites from slot 0. `req_write` high with `shift_en` low launches a frame holding 0x06, then a frame holding 0x02, the address bytes and the buffer slots in order. With no stored byte, the launch is ignored.
- R9: After each erase, protect or program frame, the block sends two-byte 0x05 frames repeatedly until bit 0 of the returned byte is 0. Only then does `busy` drop.
- R10: `busy` rises on the edge that accepts a request and falls on the edge that releases `spi_cs_n` for the last time. Requests and shifted bytes arriving while `busy` is high are ignored.
- R11: When several requests are present on the same edge, only one is taken, in this priority: identifier read, status read, erase, protect, program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sid | input | 1 | Request identifier read |
| req_status | input | 1 | Request status read |
| req_erase | input | 1 | Request sector erase at `addr` |
| req_protect | input | 1 | Request write of `din` into the status byte |
| req_write | input | 1 | Page write: byte loading with `shift_en`, launch without it |
| shift_en | input | 1 | Store `din` into the page buffer this cycle |
| addr | input | ADDR_W | Target address for erase and program |
| din | input | 8 | Protection value or page data byte |
| id_out | output | 8 | Last identifier read |
| status_out | output | 8 | Last status byte read by a status request |
| busy | output | 1 | Operation in progress |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A bench flash model decodes every frame and responds to it. Protection values are swept across all-zero, all-one, alternating and single-bit patterns. The status read that follows each sweep shows whether `din` reached the device unaltered. Erase addresses run from all zeros through all ones and mixed patterns, which exposes byte ordering and dropped address bytes. Page writes are tried with a short run, with an empty buffer, and with 258 bytes, which shows whether the buffer wraps and overwrites its first slots. Simultaneous requests, requests during busy, requests in the reset holdoff and a reset in the middle of a frame each separate correct sequencing from a leaky one.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    localparam logic [7:0] OPC_RDID  = 8'hAB;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_ERASE = 8'hD8;
    localparam logic [7:0] OPC_PROG  = 8'h02;

    localparam int unsigned SID_DUMMY = 3;

    typedef enum logic [2:0] {
        OP_SID,
        OP_STATUS,
        OP_ERASE,
        OP_PROTECT,
        OP_WRITE
    } op_e;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_MAIN,
        FR_POLL
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_XFER,
        ST_GAP
    } state_e;

    typedef struct packed {
        op_e         op;
        logic [31:0] addr;
        logic [7:0]  data;
        logic [15:0] nbytes;
    } cmd_t;

    function automatic logic alters_flash(op_e op);
        return (op == OP_ERASE) || (op == OP_PROTECT) || (op == OP_WRITE);
    endfunction

    function automatic logic [7:0] opcode_of(op_e op);
        case (op)
            OP_SID:     return OPC_RDID;
            OP_STATUS:  return OPC_RDSR;
            OP_ERASE:   return OPC_ERASE;
            OP_PROTECT: return OPC_WRSR;
            OP_WRITE:   return OPC_PROG;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] frame_len(frame_e fr, op_e op,
                                              int unsigned addr_bytes,
                                              logic [15:0] nbytes);
        case (fr)
            FR_WREN: return 16'd1;
            FR_POLL: return 16'd2;
            default: begin
                case (op)
                    OP_SID:     return 16'(2 + SID_DUMMY);
                    OP_STATUS:  return 16'd2;
                    OP_PROTECT: return 16'd2;
                    OP_ERASE:   return 16'(1 + addr_bytes);
                    default:    return 16'(1 + addr_bytes) + nbytes;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/sflash_bit_engine.sv
module sflash_bit_engine (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic       active;
    logic [2:0] bit_cnt;
    logic [7:0] sreg;

    assign mosi = sreg[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            done    <= 1'b0;
            bit_cnt <= '0;
            sreg    <= '0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    sreg    <= tx_byte;
                    bit_cnt <= '0;
                end
            end else if (!sck) begin
                sck     <= 1'b1;
                rx_byte <= {rx_byte[6:0], miso};
            end else begin
                sck <= 1'b0;
                if (bit_cnt == 3'd7) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                    sreg    <= {sreg[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/sflash_page_buf.sv
module sflash_page_buf #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [AW:0]   count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;

    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= (32'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            if (32'(count) != DEPTH) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sflash_req_arb.sv
module sflash_req_arb
    import sflash_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic req_sid,
    input  logic req_status,
    input  logic req_erase,
    input  logic req_protect,
    input  logic req_write,
    input  logic shift_en,
    input  logic buf_has_data,
    output logic accept,
    output op_e  op,
    output logic load
);
    logic [1:0] holdoff;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            holdoff <= 2'd2;
        end else if (holdoff != 2'd0) begin
            holdoff <= holdoff - 2'd1;
        end
    end

    assign ready = idle && (holdoff == 2'd0);
    assign load  = ready && req_write && shift_en;

    always_comb begin
        accept = ready;
        op     = OP_SID;
        if (req_sid) begin
            op = OP_SID;
        end else if (req_status) begin
            op = OP_STATUS;
        end else if (req_erase) begin
            op = OP_ERASE;
        end else if (req_protect) begin
            op = OP_PROTECT;
        end else if (req_write && !shift_en && buf_has_data) begin
            op = OP_WRITE;
        end else begin
            accept = 1'b0;
        end
    end
endmodule

// File: rtl/sflash_cmd_ctrl.sv
module sflash_cmd_ctrl
    import sflash_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_sid,
    input  logic              req_status,
    input  logic              req_erase,
    input  logic              req_protect,
    input  logic              req_write,
    input  logic              shift_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        id_out,
    output logic [7:0]        status_out,
    output logic              busy,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int unsigned ADDR_BYTES = ADDR_W / 8;
    localparam int unsigned HDR_BYTES  = 1 + ADDR_BYTES;
    localparam int unsigned PAGE_AW    = $clog2(PAGE_BYTES);

    state_e            state;
    frame_e            frame;
    cmd_t              cmd;
    logic [15:0]       idx;
    logic [15:0]       len;
    logic              accept;
    op_e               req_op;
    logic              load;
    logic              eng_done;
    logic [7:0]        eng_rx;
    logic [7:0]        tx_byte;
    logic [7:0]        buf_rd;
    logic [PAGE_AW:0]  buf_count;
    logic [PAGE_AW-1:0] rd_idx;
    logic [1:0]        apos;
    logic [31:0]       sh_addr;
    logic              launch_write;

    assign busy         = (state != ST_IDLE);
    assign launch_write = accept && (req_op == OP_WRITE);

    sflash_req_arb u_arb (
        .clk          (clk),
        .rst          (rst),
        .idle         (state == ST_IDLE),
        .req_sid      (req_sid),
        .req_status   (req_status),
        .req_erase    (req_erase),
        .req_protect  (req_protect),
        .req_write    (req_write),
        .shift_en     (shift_en),
        .buf_has_data (buf_count != '0),
        .accept       (accept),
        .op           (req_op),
        .load         (load)
    );

    sflash_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load),
        .wr_data (din),
        .clr     (launch_write),
        .rd_idx  (rd_idx),
        .rd_data (buf_rd),
        .count   (buf_count)
    );

    sflash_bit_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (state == ST_START),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    assign len     = frame_len(frame, cmd.op, ADDR_BYTES, cmd.nbytes);
    assign rd_idx  = idx[PAGE_AW-1:0] - PAGE_AW'(HDR_BYTES);
    assign apos    = 2'(ADDR_BYTES) - idx[1:0];
    assign sh_addr = cmd.addr >> {apos, 3'b000};

    always_comb begin
        tx_byte = 8'h00;
        case (frame)
            FR_WREN: tx_byte = OPC_WREN;
            FR_POLL: tx_byte = (idx == 16'd0) ? OPC_RDSR : 8'h00;
            default: begin
                if (idx == 16'd0) begin
                    tx_byte = opcode_of(cmd.op);
                end else begin
                    case (cmd.op)
                        OP_PROTECT: tx_byte = cmd.data;
                        OP_ERASE, OP_WRITE:
                            tx_byte = (idx <= 16'(ADDR_BYTES)) ? sh_addr[7:0] : buf_rd;
                        default: tx_byte = 8'h00;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            frame      <= FR_MAIN;
            cmd        <= '0;
            idx        <= '0;
            spi_cs_n   <= 1'b1;
            id_out     <= '0;
            status_out <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd.op     <= req_op;
                        cmd.addr   <= 32'(addr);
                        cmd.data   <= din;
                        cmd.nbytes <= 16'(buf_count);
                        frame      <= alters_flash(req_op) ? FR_WREN : FR_MAIN;
                        idx        <= '0;
                        state      <= ST_START;
                    end
                end
                ST_START: begin
                    spi_cs_n <= 1'b0;
                    state    <= ST_XFER;
                end
                ST_XFER: begin
                    if (eng_done) begin
                        if (idx == len - 16'd1) begin
                            spi_cs_n <= 1'b1;
                            idx      <= '0;
                            case (frame)
                                FR_WREN: begin
                                    frame <= FR_MAIN;
                                    state <= ST_GAP;
                                end
                                FR_MAIN: begin
                                    if (cmd.op == OP_SID) id_out <= eng_rx;
                                    if (cmd.op == OP_STATUS) status_out <= eng_rx;
                                    if (alters_flash(cmd.op)) begin
                                        frame <= FR_POLL;
                                        state <= ST_GAP;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                default: begin
                                    state <= eng_rx[0] ? ST_GAP : ST_IDLE;
                                end
                            endcase
                        end else begin
                            idx   <= idx + 16'd1;
                            state <= ST_START;
                        end
                    end
                end
                default: state <= ST_START;
            endcase
        end
    end
endmodule

// File: rtl/sflash_cmd_ctrl_chk.sv
module sflash_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic [7:0] id_out,
    input logic [7:0] status_out
);
    // R10: the select is low only inside an operation
    p_cs_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

    // R10: busy ends only together with a released select
    p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> spi_cs_n);

    // R5: serial clock pulses only inside a frame
    p_sck_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> !spi_cs_n);

    // R5: data out holds while the serial clock is high
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R1: no operation starts in the two cycles after reset
    p_holdoff1_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy);
    p_holdoff2_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst, 2) |-> !busy);

    // R3 / R4: results change only when an operation finishes
    p_results_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(id_out) && $stable(status_out)));
endmodule

bind sflash_cmd_ctrl sflash_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_sflash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_sflash_cmd_ctrl;
    localparam int AB = 3;
    localparam logic [7:0] FLASH_ID = 8'hC5;
    localparam int WIP_POLLS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_sid = 0, req_status = 0, req_erase = 0, req_protect = 0, req_write = 0, shift_en = 0;
    logic [23:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  id_out, status_out;
    logic busy, spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sflash_cmd_ctrl dut (
        .clk(clk), .rst(rst), .req_sid(req_sid), .req_status(req_status),
        .req_erase(req_erase), .req_protect(req_protect), .req_write(req_write),
        .shift_en(shift_en), .addr(addr), .din(din), .id_out(id_out),
        .status_out(status_out), .busy(busy), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash responder ----------------
    logic [7:0] log_mem [0:4095];
    int   fstart [0:511];
    int   fcount = 0;
    int   lp = 0;
    int   bitn = 0;
    logic [7:0] cur = '0;
    logic [7:0] cur_op = '0;
    logic [7:0] sr = 8'h5C;
    int   wip = 0;
    bit   wel = 0;
    int   viol = 0;
    logic prev_sck = 0, prev_mosi = 0;

    function automatic logic resp_bit(int n);
        logic [7:0] sv;
        int b;
        b  = n / 8;
        sv = {sr[7:1], (wip != 0)};
        if (cur_op == 8'hAB && b >= 4) return FLASH_ID[7 - (n % 8)];
        if (cur_op == 8'h05 && b >= 1) return sv[7 - (n % 8)];
        return 1'b0;
    endfunction

    always @(negedge spi_cs_n) begin
        bitn = 0;
        cur_op = 8'h00;
        fstart[fcount] = lp;
        fcount++;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cur = {cur[6:0], spi_mosi};
            bitn++;
            if (bitn % 8 == 0) begin
                log_mem[lp] = cur;
                lp++;
                if (bitn == 8) cur_op = cur;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && bitn >= 8) spi_miso = resp_bit(bitn);
    end

    always @(posedge spi_cs_n) begin
        if (fcount > 0) begin
            int f, len;
            logic [7:0] op;
            f   = fcount - 1;
            len = lp - fstart[f];
            op  = (len > 0) ? log_mem[fstart[f]] : 8'h00;
            if (op == 8'h06) wel = 1;
            else if (op == 8'h01 && wel && len >= 2) begin
                sr = log_mem[fstart[f] + 1] & 8'hFE; wip = WIP_POLLS; wel = 0;
            end else if ((op == 8'hD8 || op == 8'h02) && wel && len > AB) begin
                wip = WIP_POLLS; wel = 0;
            end else if (op == 8'h05 && wip > 0) wip--;
        end
    end

    // R5 protocol monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sck && prev_sck && spi_mosi !== prev_mosi) viol++;
            if (spi_sck && spi_cs_n) viol++;
        end
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    // ---------------- helpers ----------------
    function automatic int fb(int f, int i);
        return int'(log_mem[fstart[f] + i]);
    endfunction

    function automatic int flen(int f);
        return ((f + 1 < fcount) ? fstart[f + 1] : lp) - fstart[f];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: req_sid = 1;
            1: req_status = 1;
            2: req_erase = 1;
            3: req_protect = 1;
            default: req_write = 1;
        endcase
        @(negedge clk);
        req_sid = 0; req_status = 0; req_erase = 0; req_protect = 0; req_write = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic check_polls(input int f0, input string tag);
        for (int k = 0; k <= WIP_POLLS; k++) begin
            chk(fb(f0 + k, 0) == 8'h05 && flen(f0 + k) == 2, tag, fb(f0 + k, 0), 8'h05);
        end
    endtask

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int f0;
        logic [7:0] pv [8];
        logic [23:0] av [4];
        pv = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
        av = '{24'h000000, 24'hFFFFFF, 24'h12AB34, 24'h800001};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && spi_cs_n == 1 && spi_sck == 0, "R1 reset pins", {busy, spi_cs_n, spi_sck}, 3'b010);
        chk(id_out == 0 && status_out == 0, "R1 reset results", {id_out, status_out}, 0);

        // R1 holdoff: request during the two cycles after release is ignored
        rst = 0; req_sid = 1;
        @(negedge clk); @(negedge clk);
        req_sid = 0;
        repeat (4) @(negedge clk);
        chk(busy == 0 && fcount == 0, "R1 holdoff", fcount, 0);

        // R3 identifier read
        f0 = fcount;
        pulse(0);
        chk(busy == 1, "R10 busy after accept", busy, 1);
        wait_idle();
        chk(fcount - f0 == 1 && flen(f0) == 5, "R3 frame shape", flen(f0), 5);
        chk(fb(f0, 0) == 8'hAB && fb(f0, 1) == 0 && fb(f0, 2) == 0 && fb(f0, 3) == 0,
            "R3 opcode and dummies", fb(f0, 0), 8'hAB);
        chk(id_out == FLASH_ID, "R3 id_out", id_out, FLASH_ID);

        // R4 status read
        f0 = fcount;
        pulse(1);
        wait_idle();
        chk(fcount - f0 == 1 && fb(f0, 0) == 8'h05 && flen(f0) == 2, "R4 frame", fb(f0, 0), 8'h05);
        chk(status_out == 8'h5C, "R4 status_out", status_out, 8'h5C);

        // R10 request during busy is ignored
        f0 = fcount;
        pulse(0);
        repeat (5) @(negedge clk);
        pulse(1);
        wait_idle();
        chk(fcount - f0 == 1, "R10 ignored while busy", fcount - f0, 1);
        chk(status_out == 8'h5C, "R10 status untouched", status_out, 8'h5C);

        // R11 priority: identifier over status
        f0 = fcount;
        @(negedge clk); req_sid = 1; req_status = 1;
        @(negedge clk); req_sid = 0; req_status = 0;
        wait_idle();
        chk(fcount - f0 == 1 && fb(f0, 0) == 8'hAB, "R11 sid over status", fb(f0, 0), 8'hAB);

        // R7 / R9 protect sweep
        foreach (pv[i]) begin
            f0 = fcount;
            din = pv[i];
            pulse(3);
            din = 8'h00;
            wait_idle();
            chk(fcount - f0 == 2 + WIP_POLLS + 1, "R9 frame count protect", fcount - f0, 2 + WIP_POLLS + 1);
            chk(fb(f0, 0) == 8'h06 && flen(f0) == 1, "R7 write enable first", fb(f0, 0), 8'h06);
            chk(fb(f0 + 1, 0) == 8'h01 && fb(f0 + 1, 1) == int'(pv[i]), "R7 protect byte",
                fb(f0 + 1, 1), pv[i]);
            check_polls(f0 + 2, "R9 poll frames protect");
            pulse(1);
            wait_idle();
            chk(status_out == (pv[i] & 8'hFE), "R4 status after protect", status_out, pv[i] & 8'hFE);
        end

        // R11 priority: erase over protect and write
        f0 = fcount;
        addr = 24'h0A0B0C;
        @(negedge clk); req_erase = 1; req_protect = 1; req_write = 1;
        @(negedge clk); req_erase = 0; req_protect = 0; req_write = 0;
        wait_idle();
        chk(fb(f0 + 1, 0) == 8'hD8, "R11 erase over protect", fb(f0 + 1, 0), 8'hD8);

        // R6 erase sweep
        foreach (av[i]) begin
            f0 = fcount;
            addr = av[i];
            pulse(2);
            wait_idle();
            chk(fb(f0, 0) == 8'h06 && fb(f0 + 1, 0) == 8'hD8 && flen(f0 + 1) == 1 + AB,
                "R6 erase frame", flen(f0 + 1), 1 + AB);
            chk(fb(f0 + 1, 1) == int'(av[i][23:16]) && fb(f0 + 1, 2) == int'(av[i][15:8]) &&
                fb(f0 + 1, 3) == int'(av[i][7:0]), "R6 address order",
                {fb(f0 + 1, 1), fb(f0 + 1, 2), fb(f0 + 1, 3)}, av[i]);
            chk(fcount - f0 == 2 + WIP_POLLS + 1, "R9 frame count erase", fcount - f0, 2 + WIP_POLLS + 1);
        end

        // R8 launch with an empty buffer is ignored
        f0 = fcount;
        pulse(4);
        repeat (4) @(negedge clk);
        chk(busy == 0 && fcount == f0, "R8 empty launch ignored", fcount - f0, 0);

        // R8 short page
        f0 = fcount;
        addr = 24'h345678;
        @(negedge clk); req_write = 1; shift_en = 1;
        for (int i = 0; i < 5; i++) begin
            din = pat(i);
            @(negedge clk);
        end
        shift_en = 0;
        @(negedge clk); req_write = 0;
        wait_idle();
        chk(fb(f0 + 1, 0) == 8'h02 && flen(f0 + 1) == 1 + AB + 5, "R8 short page frame", flen(f0 + 1), 1 + AB + 5);
        chk(fb(f0 + 1, 1) == 8'h34 && fb(f0 + 1, 3) == 8'h78, "R8 page address", fb(f0 + 1, 1), 8'h34);
        for (int i = 0; i < 5; i++) begin
            chk(fb(f0 + 1, 1 + AB + i) == int'(pat(i)), "R8 short page data", fb(f0 + 1, 1 + AB + i), pat(i));
        end
        check_polls(f0 + 2, "R9 poll frames program");

        // R8 wrap: 258 bytes, first two slots overwritten
        f0 = fcount;
        @(negedge clk); req_write = 1; shift_en = 1;
        for (int i = 0; i < 258; i++) begin
            din = pat(i);
            @(negedge clk);
        end
        shift_en = 0;
        @(negedge clk); req_write = 0;
        wait_idle();
        chk(flen(f0 + 1) == 1 + AB + 256, "R8 wrap length", flen(f0 + 1), 1 + AB + 256);
        begin
            int bad = 0;
            for (int j = 0; j < 256; j++) begin
                if (fb(f0 + 1, 1 + AB + j) != int'((j < 2) ? pat(256 + j) : pat(j))) bad++;
            end
            chk(bad == 0, "R8 wrap contents", bad, 0);
        end

        // R5 serial timing over the whole run
        chk(viol == 0, "R5 sck/mosi discipline", viol, 0);

        // R2 reset in the middle of an operation
        addr = 24'h111111;
        pulse(2);
        repeat (30) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(spi_cs_n == 1 && busy == 0 && spi_sck == 0, "R2 abort", {spi_cs_n, busy, spi_sck}, 3'b100);
        @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        f0 = fcount;
        pulse(1);
        wait_idle();
        chk(fcount - f0 == 1 && status_out == (pv[7] & 8'hFE), "R2 usable after abort",
            status_out, pv[7] & 8'hFE);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule